// File: doc/BRIEF.md
# Match and Capture Timer

A 32-bit up-counter fed through a 32-bit prescaler. In timer mode every clock is a source event. In counter mode only the chosen edges of an external input are source events. The prescaler divides the source events, and each division step is one count step of the main counter.

Four compare registers watch the count. On a count step that leaves a compared value, each channel can run on, reset the counter, or stop it. Each channel can also set a sticky interrupt flag and send a one-cycle DMA request pulse. Two capture inputs each store the count on a selected edge and can flag an interrupt.

Software reaches every register through a simple write strobe and address port. The read data is combinational.

Top module: `cmp_cap_timer`

## Requirements
- R1: After reset the count, the prescale count, every flag, `irq_o` and `dma_req_o` are zero.
- R2: In timer mode (control bit 0 = run, bit 1 = 0), the prescale count (address 2) rises by one each clock up to the prescale value (address 1), then returns to 0 while the count (address 3) advances by one. After K clocks the count is K/(P+1) and the prescale count is K mod (P+1). Control bit 4 holds both counts at zero.
- R3: In counter mode (control bit 1 = 1), only synchronized edges of `ext_i` are source events. Control bits 3:2 choose the edge: 01 rising, 10 falling, 11 both. Clocks with no qualifying edge do not advance the count.
- R4: When match channel i has its reset bit set (match-control bit 3i+1), a count step taken while the count equals match register i (address 4+i) makes the next count 0.
- R5: When match channel i has its stop bit set (match-control bit 3i+2), such a step leaves the count unchanged and clears the run bit.
- R6: A channel with neither action bit set lets the count run on past the match value.
- R7: The flag register (address 11) is sticky: bits 3:0 are match events and bits 5:4 are capture events. Writing a one clears that bit, and zero bits of the write leave flags unchanged. `irq_o` is the OR of all flags.
- R8: A match flag is set only when that channel's interrupt bit (match-control bit 3i, address 8) is set.
- R9: Capture channel j (value at address 12+j) stores the count on the edge chosen by capture-control bits 3j+1:3j (address 9, same encoding as R3). Other edges leave the stored value unchanged.
- R10: A capture event sets flag bit 4+j only when capture-control bit 3j+2 is set.
- R11: When DMA enable bit i (address 10) is set, each match event of channel i produces exactly one one-cycle pulse on `dma_req_o[i]`.
- R12: The count register is writable. A write overrides any count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| ext_i | input | 1 | External count input (asynchronous) |
| cap_i | input | 2 | Capture inputs (asynchronous) |
| irq_o | output | 1 | OR of all sticky flags |
| dma_req_o | output | 4 | Per-channel DMA request pulses |

## Verification
- **Timer-mode results:** a register write takes effect at the clock edge that samples it. In timer mode each later edge is one source event, so after the enabling write the bench counts K edges and reads at the following falling edge. It then expects K/(P+1) exactly.
- **Synchronized inputs:** external and capture inputs pass two synchronizer flops and an edge flop. Their effect is therefore due on the third edge after the change. The bench holds each level for four cycles and reads after the input has settled.
- **Flags and DMA:** flags and DMA pulses are registered from the step that hits a match, so both appear one edge after that step. The bench counts DMA pulses at every falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRE   = 4'd1;
  localparam logic [ADDR_W-1:0] A_PCNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MATCH = 4'd4;
  localparam logic [ADDR_W-1:0] A_MCTL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CCTL  = 4'd9;
  localparam logic [ADDR_W-1:0] A_DMA   = 4'd10;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd11;
  localparam logic [ADDR_W-1:0] A_CAP   = 4'd12;

  localparam int CTL_RUN  = 0;
  localparam int CTL_MODE = 1;
  localparam int CTL_SEL  = 2;
  localparam int CTL_SRST = 4;
  localparam int CTL_W    = 5;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       d_i,
  input  logic [1:0] sel_i,  // bit0 rising, bit1 falling
  output logic       evt_o
);
  logic [STAGES:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
  assign evt_o = (sel_i[0] & rise) | (sel_i[1] & fall);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            run_i,
  input  logic                            cnt_mode_i,
  input  logic                            srst_i,
  input  logic                            ext_evt_i,
  input  logic [CNT_W-1:0]                pre_i,
  input  logic [N_MATCH-1:0][CNT_W-1:0]   match_i,
  input  logic [N_MATCH-1:0]              m_rst_i,
  input  logic [N_MATCH-1:0]              m_stop_i,
  input  logic                            cnt_we_i,
  input  logic [CNT_W-1:0]                cnt_wdata_i,
  output logic [CNT_W-1:0]                cnt_o,
  output logic [CNT_W-1:0]                pcnt_o,
  output logic                            tick_o,
  output logic [N_MATCH-1:0]              m_evt_o
);
  logic [CNT_W-1:0] cnt_q, pcnt_q;
  logic src, pre_wrap, any_rst, any_stop;

  assign src      = run_i & ~srst_i & (cnt_mode_i ? ext_evt_i : 1'b1);
  // >= so a lowered prescale value wraps at once
  assign pre_wrap = pcnt_q >= pre_i;
  assign tick_o   = src & pre_wrap;

  for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
    assign m_evt_o[i] = tick_o & (cnt_q == match_i[i]);
  end

  assign any_rst  = |(m_evt_o & m_rst_i);
  assign any_stop = |(m_evt_o & m_stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (srst_i) pcnt_q <= '0;
    else if (src)    pcnt_q <= pre_wrap ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (srst_i)   cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_wdata_i;
    else if (tick_o) begin
      if (any_rst)       cnt_q <= '0;
      else if (!any_stop) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign pcnt_o = pcnt_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !cnt_we_i && !srst_i) |=> $stable(cnt_q));
  // R4
  match_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_rst && !cnt_we_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cmp_cap_timer.sv
module cmp_cap_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic               ext_i,
  input  logic [N_CAP-1:0]   cap_i,
  output logic               irq_o,
  output logic [N_MATCH-1:0] dma_req_o
);
  localparam int MCTL_W = 3 * N_MATCH;
  localparam int CCTL_W = 3 * N_CAP;
  localparam int FLAG_W = N_MATCH + N_CAP;

  logic [CTL_W-1:0]                ctrl_q;
  logic [CNT_W-1:0]                pre_q;
  logic [N_MATCH-1:0][CNT_W-1:0]   match_q;
  logic [MCTL_W-1:0]               mctl_q;
  logic [CCTL_W-1:0]               cctl_q;
  logic [N_MATCH-1:0]              dma_en_q, dma_q;
  logic [FLAG_W-1:0]               flag_q, flag_set, flag_clr;
  logic [N_CAP-1:0][CNT_W-1:0]     cap_q;

  logic [N_MATCH-1:0] m_irq, m_rst, m_stop, m_evt;
  logic [N_CAP-1:0]   cap_evt, cap_irq;
  logic [CNT_W-1:0]   cnt, pcnt;
  logic ext_evt, tick, stop_hit;
  logic we_ctrl, we_flag;

  assign we_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign we_flag = wr_en_i && (addr_i == A_FLAG);

  for (genvar i = 0; i < N_MATCH; i++) begin : g_mctl
    assign m_irq[i]  = mctl_q[3*i];
    assign m_rst[i]  = mctl_q[3*i+1];
    assign m_stop[i] = mctl_q[3*i+2];
  end

  tmr_edge_sync #(.STAGES(2)) u_ext_sync (
    .clk_i, .rst_ni, .d_i(ext_i), .sel_i(ctrl_q[CTL_SEL+:2]), .evt_o(ext_evt)
  );

  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    assign cap_irq[j] = cctl_q[3*j+2];
    tmr_edge_sync #(.STAGES(2)) u_cap_sync (
      .clk_i, .rst_ni, .d_i(cap_i[j]), .sel_i(cctl_q[3*j+:2]), .evt_o(cap_evt[j])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cap_q[j] <= '0;
      else if (cap_evt[j]) cap_q[j] <= cnt;
    end
    // R9
    cap_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_evt[j] |=> (cap_q[j] == $past(cnt)));
  end

  tmr_core #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_core (
    .clk_i, .rst_ni,
    .run_i(ctrl_q[CTL_RUN]), .cnt_mode_i(ctrl_q[CTL_MODE]), .srst_i(ctrl_q[CTL_SRST]),
    .ext_evt_i(ext_evt), .pre_i(pre_q), .match_i(match_q),
    .m_rst_i(m_rst), .m_stop_i(m_stop),
    .cnt_we_i(wr_en_i && (addr_i == A_CNT)), .cnt_wdata_i(wdata_i),
    .cnt_o(cnt), .pcnt_o(pcnt), .tick_o(tick), .m_evt_o(m_evt)
  );

  assign stop_hit = |(m_evt & m_stop);
  assign flag_set = {cap_evt & cap_irq, m_evt & m_irq};
  assign flag_clr = we_flag ? wdata_i[FLAG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      pre_q    <= '0;
      match_q  <= '0;
      mctl_q   <= '0;
      cctl_q   <= '0;
      dma_en_q <= '0;
      flag_q   <= '0;
      dma_q    <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= wdata_i[CTL_W-1:0];
      if (stop_hit) ctrl_q[CTL_RUN] <= 1'b0;
      if (wr_en_i && addr_i == A_PRE)  pre_q    <= wdata_i;
      if (wr_en_i && addr_i == A_MCTL) mctl_q   <= wdata_i[MCTL_W-1:0];
      if (wr_en_i && addr_i == A_CCTL) cctl_q   <= wdata_i[CCTL_W-1:0];
      if (wr_en_i && addr_i == A_DMA)  dma_en_q <= wdata_i[N_MATCH-1:0];
      for (int i = 0; i < N_MATCH; i++)
        if (wr_en_i && addr_i == A_MATCH + ADDR_W'(i)) match_q[i] <= wdata_i;
      // a new event wins over a same-cycle clear
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      dma_q  <= m_evt & dma_en_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o = CNT_W'(ctrl_q);
      A_PRE:  rdata_o = pre_q;
      A_PCNT: rdata_o = pcnt;
      A_CNT:  rdata_o = cnt;
      A_MCTL: rdata_o = CNT_W'(mctl_q);
      A_CCTL: rdata_o = CNT_W'(cctl_q);
      A_DMA:  rdata_o = CNT_W'(dma_en_q);
      A_FLAG: rdata_o = CNT_W'(flag_q);
      default: rdata_o = '0;
    endcase
    for (int i = 0; i < N_MATCH; i++)
      if (addr_i == A_MATCH + ADDR_W'(i)) rdata_o = match_q[i];
    for (int j = 0; j < N_CAP; j++)
      if (addr_i == A_CAP + ADDR_W'(j)) rdata_o = cap_q[j];
  end

  assign irq_o     = |flag_q;
  assign dma_req_o = dma_q;

  // R5
  stop_clears_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_hit |=> !ctrl_q[CTL_RUN]);
  // R11
  dma_after_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dma_req_o) |-> $past(|m_evt));
  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_flag && flag_set == '0) |=> $stable(flag_q));
  // R2
  tick_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> ctrl_q[CTL_RUN]);
endmodule

// File: tb/cmp_cap_timer_bench.sv
`timescale 1ns/1ps
module cmp_cap_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext = 1'b0;
  logic [1:0]  cap = '0;
  logic        irq;
  logic [3:0]  dma;
  int checks = 0;
  int fails = 0;
  int dma_cnt = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  cmp_cap_timer u_cmp_cap_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_i(ext), .cap_i(cap), .irq_o(irq), .dma_req_o(dma)
  );

  always @(negedge clk) if (dma[0]) dma_cnt++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ext(input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); ext = 1'b1;
      repeat (4) @(negedge clk);
      ext = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd3, v);  chk("R1 count", v, 0);
    rd(4'd2, v);  chk("R1 prescale count", v, 0);
    rd(4'd11, v); chk("R1 flags", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 dma", {28'd0, dma}, 0);

    // R2 timer mode sweep over prescale and run length
    for (int p = 0; p < 4; p++) begin
      for (int k = 5; k < 12; k += 3) begin
        wr(4'd0, 32'h10);
        wr(4'd1, p);
        wr(4'd0, 32'h1);
        edges(k);
        rd(4'd3, v); chk("R2 count", v, k / (p + 1));
        rd(4'd2, v); chk("R2 prescale count", v, k % (p + 1));
        wr(4'd0, 32'h0);
      end
    end

    // R3 counter mode: idle clocks, then rising/falling/both and prescale
    wr(4'd0, 32'h10); wr(4'd1, 0); wr(4'd0, 32'h7);
    edges(20);
    rd(4'd3, v); chk("R3 idle no edges", v, 0);
    pulse_ext(5); edges(4);
    rd(4'd3, v); chk("R3 rising", v, 5);
    wr(4'd0, 32'h10); wr(4'd0, 32'hB);
    pulse_ext(5); edges(4);
    rd(4'd3, v); chk("R3 falling", v, 5);
    wr(4'd0, 32'h10); wr(4'd0, 32'hF);
    pulse_ext(5); edges(4);
    rd(4'd3, v); chk("R3 both", v, 10);
    wr(4'd0, 32'h10); wr(4'd1, 1); wr(4'd0, 32'h7);
    pulse_ext(6); edges(4);
    rd(4'd3, v); chk("R3 prescaled", v, 3);
    wr(4'd0, 32'h10); wr(4'd1, 0);

    // R4 reset on match, R11 DMA pulses, R8 flag with irq enabled
    wr(4'd4, 4); wr(4'd8, 32'h3); wr(4'd10, 32'h1); wr(4'd11, 32'h3F);
    dma_cnt = 0;
    wr(4'd0, 32'h1);
    edges(13);
    rd(4'd3, v); chk("R4 count wraps", v, 13 % 5);
    chk("R11 dma pulses", dma_cnt, 13 / 5);
    rd(4'd11, v); chk("R8 match flag", v, 32'h1);
    chk("R7 irq", {31'd0, irq}, 1);
    wr(4'd0, 32'h10);

    // R5 stop on match1, R6 match0 runs on with irq only
    wr(4'd5, 6); wr(4'd8, 32'h29); wr(4'd11, 32'h3F);
    wr(4'd0, 32'h1);
    edges(20);
    rd(4'd3, v); chk("R5 count holds", v, 6);
    rd(4'd0, v); chk("R5 run cleared", v, 0);
    rd(4'd11, v); chk("R6 flags", v, 32'h3);

    // R7 write-one-to-clear
    wr(4'd11, 32'h1); rd(4'd11, v); chk("R7 clear bit0", v, 32'h2);
    wr(4'd11, 32'h0); rd(4'd11, v); chk("R7 zero write", v, 32'h2);
    wr(4'd11, 32'h2); rd(4'd11, v); chk("R7 clear bit1", v, 0);
    chk("R7 irq low", {31'd0, irq}, 0);

    // R8 stop without irq
    wr(4'd0, 32'h10); wr(4'd6, 3); wr(4'd8, 32'h100);
    wr(4'd0, 32'h1);
    edges(10);
    rd(4'd3, v); chk("R8 stopped count", v, 3);
    rd(4'd11, v); chk("R8 no flag", v, 0);
    chk("R8 irq low", {31'd0, irq}, 0);

    // R9/R10 capture, R12 count write
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h1234);
    rd(4'd3, v); chk("R12 count write", v, 32'h1234);
    wr(4'd9, 32'h1D);
    wr(4'd11, 32'h3F);
    @(negedge clk); cap[0] = 1'b1; edges(5);
    rd(4'd12, v); chk("R9 cap0 rising", v, 32'h1234);
    rd(4'd11, v); chk("R10 cap0 flag", v, 32'h10);
    wr(4'd3, 32'h55);
    @(negedge clk); cap[0] = 1'b0; edges(5);
    rd(4'd12, v); chk("R9 cap0 falling ignored", v, 32'h1234);
    @(negedge clk); cap[1] = 1'b1; edges(5);
    rd(4'd13, v); chk("R9 cap1 rising", v, 32'h55);
    wr(4'd3, 32'h77);
    @(negedge clk); cap[1] = 1'b0; edges(5);
    rd(4'd13, v); chk("R9 cap1 falling", v, 32'h77);
    rd(4'd11, v); chk("R10 cap1 no flag", v, 32'h10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule